// File: doc/BRIEF.md
# I2C Serial Clock Generator with Duty Control

This block produces the serial clock for an I2C master from a faster source clock. A single control word holds three byte fields. The low field sets the length of the low phase. The upper field sets the length of the high phase. When the upper field is zero, the high phase copies the low phase and the clock is symmetric. That is the standard-mode setting. A nonzero upper field of roughly half the low field gives the lopsided two-thirds-low clock used in the fast modes. Each phase is longer than its field by a fixed overhead of three source cycles. The middle field is a high-speed divider, which is only held and presented on an output for a later high-speed engine.

The block does not drive the pad. It reports `scl_rel`: 1 means release the line (let it float high) and 0 means pull it low. The sampled line level comes back on `scl_in`. The high phase is not timed until the line is seen high, so a target that holds the clock low (clock stretching) lengthens the period and cannot shorten it. Three single-cycle strobes tell the bit engine where each phase starts: the start of low, where data may change; the release point; and the first timed high cycle, where data is sampled. All pins are plain control and status signals. There is no data stream, so no valid/ready handshake applies.

Top module: `i2c_scl_gen`

## Requirements
- R1: While `enable` is low (and in reset), `scl_rel` is 1, all three strobes are 0, and both phase counters are held at zero.
- R2: The clock is low for exactly `clk_ctl[7:0] + 3` source cycles in each period.
- R3: When `clk_ctl[23:16]` is zero, the high time equals the low time, `clk_ctl[7:0] + 3` cycles, if the line is not stretched.
- R4: When `clk_ctl[23:16]` is nonzero, the high time is `clk_ctl[23:16] + 3` cycles if the line is not stretched.
- R5: The high time is counted only from the first cycle in which `scl_in` is seen high. If a target holds the line low for S released cycles, the released time grows by exactly S cycles. While `scl_in` stays low after release, the block never pulls the line low.
- R6: `fall_stb` is high only in the first low cycle. `rise_stb` is high only in the first released cycle. `smp_stb` is high only in the first cycle after `scl_in` is seen high. No two strobes are high together.
- R7: `hs_div` always equals `clk_ctl[15:8]`.
- R8: When `enable` is sampled high after being low, the next cycle is the first low cycle, with `fall_stb` high.
- R9: Dropping `enable` in mid-period releases the line on the next cycle. The next enable starts with a full-length low phase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Source clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| enable | input | 1 | Run the clock; low releases the line and clears the counters |
| clk_ctl | input | 24 | Control word: [7:0] low divider, [15:8] high-speed divider, [23:16] high divider |
| scl_in | input | 1 | Sampled level of the serial clock line |
| scl_rel | output | 1 | 1 = release the line, 0 = pull low |
| fall_stb | output | 1 | First cycle of the low phase |
| rise_stb | output | 1 | First cycle of the released phase |
| smp_stb | output | 1 | First cycle after the line is seen high |
| hs_div | output | 8 | Held high-speed divider field |

## Verification
On every cycle, the assertions check the following: the line is released while disabled, the strobes are mutually exclusive and line up with the edges, the block does not pull low while a target stretches, an enable starts a low phase, and the low phase has the configured length whenever the control word has been steady. Other behaviour is shown only by the bench's scenarios. These are the high time for both duty modes, the exact growth of the released time under stretching, the position of the sample strobe, and a full restart after a mid-period disable. The bench measures these from the pins across random and extreme divider values.

// File: rtl/i2c_scl_pkg.sv
package i2c_scl_pkg;
  // extra source cycles added to every phase
  localparam int unsigned SCL_OVERHEAD = 3;

  typedef enum logic [1:0] {
    SCL_OFF  = 2'd0,
    SCL_LOW  = 2'd1,
    SCL_REL  = 2'd2,
    SCL_HIGH = 2'd3
  } scl_state_t;
endpackage

// File: rtl/scl_len_decode.sv
module scl_len_decode #(
  parameter int DIV_W = 8,
  localparam int CTL_W = 3 * DIV_W,
  localparam int LEN_W = DIV_W + 1
) (
  input  logic [CTL_W-1:0] clk_ctl,
  output logic [LEN_W-1:0] low_len,
  output logic [LEN_W-1:0] high_len,
  output logic [DIV_W-1:0] hs_div
);
  import i2c_scl_pkg::*;

  logic [DIV_W-1:0] lo_f, hi_f;

  assign lo_f   = clk_ctl[DIV_W-1:0];
  assign hs_div = clk_ctl[2*DIV_W-1:DIV_W];
  assign hi_f   = clk_ctl[3*DIV_W-1:2*DIV_W];

  always_comb begin
    low_len  = LEN_W'(lo_f) + LEN_W'(SCL_OVERHEAD);
    // zero upper field selects the symmetric clock
    high_len = (hi_f == '0) ? low_len : LEN_W'(hi_f) + LEN_W'(SCL_OVERHEAD);
  end
endmodule

// File: rtl/scl_phase_cnt.sv
module scl_phase_cnt #(
  parameter int LEN_W = 9
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             run,
  input  logic [LEN_W-1:0] len,
  output logic             last
);
  logic [LEN_W-1:0] cnt;

  assign last = run && (cnt == len - LEN_W'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt <= '0;
    else if (clr)    cnt <= '0;
    else if (run)    cnt <= last ? '0 : cnt + LEN_W'(1);
  end
endmodule

// File: rtl/i2c_scl_gen.sv
module i2c_scl_gen #(
  parameter int DIV_W = 8,
  localparam int CTL_W = 3 * DIV_W,
  localparam int LEN_W = DIV_W + 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             enable,
  input  logic [CTL_W-1:0] clk_ctl,
  input  logic             scl_in,
  output logic             scl_rel,
  output logic             fall_stb,
  output logic             rise_stb,
  output logic             smp_stb,
  output logic [DIV_W-1:0] hs_div
);
  import i2c_scl_pkg::*;

  scl_state_t       state, nxt;
  logic [LEN_W-1:0] low_len, high_len;
  logic             lo_last, hi_last, lo_run, hi_run;

  scl_len_decode #(.DIV_W(DIV_W)) u_dec (
    .clk_ctl (clk_ctl),
    .low_len (low_len),
    .high_len(high_len),
    .hs_div  (hs_div)
  );

  assign lo_run = (state == SCL_LOW);
  // the cycle that first sees the line high is the first timed high cycle
  assign hi_run = (state == SCL_HIGH) || ((state == SCL_REL) && scl_in);

  scl_phase_cnt #(.LEN_W(LEN_W)) u_lo_cnt (
    .clk(clk), .rst_n(rst_n), .clr(!enable), .run(lo_run),
    .len(low_len), .last(lo_last)
  );

  scl_phase_cnt #(.LEN_W(LEN_W)) u_hi_cnt (
    .clk(clk), .rst_n(rst_n), .clr(!enable), .run(hi_run),
    .len(high_len), .last(hi_last)
  );

  always_comb begin
    nxt = state;
    if (!enable) nxt = SCL_OFF;
    else begin
      unique case (state)
        SCL_OFF:  nxt = SCL_LOW;
        SCL_LOW:  if (lo_last) nxt = SCL_REL;
        SCL_REL:  if (scl_in)  nxt = SCL_HIGH;
        SCL_HIGH: if (hi_last) nxt = SCL_LOW;
        default:  nxt = SCL_OFF;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= SCL_OFF;
      fall_stb <= 1'b0;
      rise_stb <= 1'b0;
      smp_stb  <= 1'b0;
    end else begin
      state    <= nxt;
      fall_stb <= (nxt == SCL_LOW)  && (state != SCL_LOW);
      rise_stb <= (nxt == SCL_REL)  && (state != SCL_REL);
      smp_stb  <= (nxt == SCL_HIGH) && (state != SCL_HIGH);
    end
  end

  assign scl_rel = (state != SCL_LOW);
endmodule

// File: rtl/i2c_scl_gen_chk.sv
module i2c_scl_gen_chk #(
  parameter int DIV_W = 8,
  localparam int CTL_W = 3 * DIV_W
) (
  input logic             clk,
  input logic             rst_n,
  input logic             enable,
  input logic [CTL_W-1:0] clk_ctl,
  input logic             scl_in,
  input logic             scl_rel,
  input logic             fall_stb,
  input logic             rise_stb,
  input logic             smp_stb
);
  localparam int RUN_W = DIV_W + 2;

  logic [RUN_W-1:0] lo_run, stab;
  logic [CTL_W-1:0] ctl_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lo_run <= '0;
      stab   <= '0;
      ctl_q  <= '0;
    end else begin
      ctl_q  <= clk_ctl;
      lo_run <= scl_rel ? '0 : lo_run + RUN_W'(1);
      if (clk_ctl != ctl_q) stab <= '0;
      else if (stab != '1)  stab <= stab + RUN_W'(1);
    end
  end

  a_r1_off_released: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |=> (scl_rel && !fall_stb && !rise_stb && !smp_stb));

  a_r6_strobes_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({fall_stb, rise_stb, smp_stb}));

  a_r6_fall_marks_edge: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(scl_rel) |-> fall_stb);

  a_r6_rise_marks_edge: assert property (@(posedge clk) disable iff (!rst_n)
    rise_stb |-> (scl_rel && $past(!scl_rel)));

  a_r5_no_pull_while_stretched: assert property (@(posedge clk) disable iff (!rst_n)
    (scl_rel && !scl_in) |=> scl_rel);

  a_r8_enable_starts_low: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(enable) |=> (!scl_rel && fall_stb));

  a_r2_low_length: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(scl_rel) && $past(enable) && (stab > lo_run + RUN_W'(2)))
      |-> (lo_run == RUN_W'(clk_ctl[DIV_W-1:0]) + RUN_W'(3)));
endmodule

bind i2c_scl_gen i2c_scl_gen_chk #(.DIV_W(DIV_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .enable(enable), .clk_ctl(clk_ctl),
  .scl_in(scl_in), .scl_rel(scl_rel), .fall_stb(fall_stb),
  .rise_stb(rise_stb), .smp_stb(smp_stb)
);

// File: tb/tb_i2c_scl_gen.sv
module tb_i2c_scl_gen;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        enable = 1'b0;
  logic [23:0] clk_ctl = '0;
  logic        hold = 1'b0;
  logic        scl_in;
  logic        scl_rel, fall_stb, rise_stb, smp_stb;
  logic [7:0]  hs_div;
  int          n_chk = 0, n_bad = 0, cyc = 0;

  always #2 clk = ~clk;

  assign scl_in = scl_rel & ~hold;

  i2c_scl_gen dut (
    .clk(clk), .rst_n(rst_n), .enable(enable), .clk_ctl(clk_ctl),
    .scl_in(scl_in), .scl_rel(scl_rel), .fall_stb(fall_stb),
    .rise_stb(rise_stb), .smp_stb(smp_stb), .hs_div(hs_div)
  );

  function automatic int exp_low(logic [23:0] c);
    return int'(c[7:0]) + 3;
  endfunction

  function automatic int exp_high(logic [23:0] c);
    return (c[23:16] == 8'd0) ? int'(c[7:0]) + 3 : int'(c[23:16]) + 3;
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // measure one full period starting at the next fall strobe; s = stretch cycles
  task automatic measure(input logic [23:0] c, input int s);
    int lo = 0, hi = 0, smp_at = 0, guard = 0;
    bit rise_ok;
    do begin @(negedge clk); guard++; end while (!fall_stb && guard < 2000);
    chk(fall_stb == 1'b1, "R6 fall strobe seen", int'(fall_stb), 1);
    hold = (s > 0);
    while (!scl_rel && lo < 2000) begin
      lo++;
      @(negedge clk);
      if (!scl_rel) chk(!fall_stb, "R6 fall strobe only first low", int'(fall_stb), 0);
    end
    chk(lo == exp_low(c), "R2 low time", lo, exp_low(c));
    rise_ok = rise_stb;
    chk(rise_ok, "R6 rise strobe at release", int'(rise_ok), 1);
    while (scl_rel && hi < 2000) begin
      hi++;
      if (smp_stb) smp_at = hi;
      if (s > 0 && hi == s + 1) hold = 1'b0;
      @(negedge clk);
    end
    hold = 1'b0;
    if (c[23:16] == 8'd0)
      chk(hi == s + exp_high(c), "R3 symmetric high time", hi, s + exp_high(c));
    else
      chk(hi == s + exp_high(c), "R4 duty high time", hi, s + exp_high(c));
    chk(smp_at == s + 2, "R5 sample strobe after line high", smp_at, s + 2);
  endtask

  task automatic run_vec(input logic [23:0] c, input int s);
    @(negedge clk);
    enable = 1'b0;
    clk_ctl = c;
    @(negedge clk);
    chk(hs_div == c[15:8], "R7 high-speed field held", int'(hs_div), int'(c[15:8]));
    enable = 1'b1;
    @(negedge clk);
    chk(!scl_rel && fall_stb, "R8 start in low", int'(scl_rel), 0);
    measure(c, s);
    measure(c, 0);
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cyc++;
      if (cyc > 150000) begin
        n_bad++;
        n_chk++;
        $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
      end
    end
  end

  initial begin
    void'($urandom(32'h5c1_0a7e));
    repeat (3) @(negedge clk);
    chk(scl_rel && !fall_stb && !rise_stb && !smp_stb, "R1 reset released", int'(scl_rel), 1);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk(scl_rel && !fall_stb && !rise_stb && !smp_stb, "R1 disabled released", int'(scl_rel), 1);

    // directed corners
    run_vec(24'h00_03_00, 0);            // smallest symmetric
    run_vec(24'h00_03_FF, 0);            // largest symmetric
    run_vec(24'h04_03_08, 0);            // fast-mode duty
    run_vec(24'hFF_03_00, 1);            // largest high field
    run_vec(24'h05_07_0A, 6);            // stretched

    // R9: disable in mid low phase, then full restart
    clk_ctl = 24'h00_03_14;
    @(negedge clk);
    enable = 1'b1;
    repeat (6) @(negedge clk);
    enable = 1'b0;
    @(negedge clk);
    chk(scl_rel && !fall_stb, "R9 release after disable", int'(scl_rel), 1);
    chk(!rise_stb && !smp_stb, "R1 no strobes when off", int'(rise_stb | smp_stb), 0);
    @(negedge clk);
    enable = 1'b1;
    @(negedge clk);
    begin
      int lo = 0;
      while (!scl_rel && lo < 2000) begin lo++; @(negedge clk); end
      chk(lo == exp_low(clk_ctl), "R9 full low after restart", lo, exp_low(clk_ctl));
    end

    // random vectors
    for (int i = 0; i < 24; i++) begin
      logic [23:0] c;
      int s;
      c[7:0]   = 8'($urandom_range(0, 60));
      c[15:8]  = 8'($urandom);
      c[23:16] = ($urandom_range(0, 1) == 0) ? 8'd0 : 8'($urandom_range(1, 30));
      s = $urandom_range(0, 7);
      run_vec(c, s);
    end

    enable = 1'b0;
    @(negedge clk);
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule